// File: doc/BRIEF.md
# Virtually Tagged Data Cache with Process Tags

This block is a direct-mapped data cache whose set index and tag both come from the virtual address. The lookup can therefore start in the same cycle a request arrives. The matching physical page number and a permission-fault flag come in on a separate translation input, and the cache samples them in that same acceptance cycle. The cache does not wait for translation before it reads its arrays.

Each line holds five things: a valid bit, a dirty bit, the virtual tag, the tag of the process that filled it, and the physical line address. The physical line address is used only to write a dirty line back. It never selects a set. A hit requires both the virtual tag and the current process identifier to match. Two processes that use the same virtual page therefore never see each other's data.

A context-switch command loads a new process identifier. It can optionally flush the cache: every dirty line is written back and then every line is invalidated, with the cache busy for the whole sweep. Misses allocate a line for both loads and stores. If the victim is dirty, it is first written to its stored physical line address, and then the new line is fetched from the translated address.

Top module: `vtc_cache`

## Requirements
- R1: After reset, `busy`, `resp_valid` and `mem_req` are low and every line is invalid, so the first access to any address misses.
- R2: A request is accepted when `req_valid` is high, `busy` is low and `ctx_valid` is low. A load that hits returns its word with a one-cycle `resp_valid` pulse in the second cycle after acceptance, with no memory transaction. `busy` is high between acceptance and the response.
- R3: On a miss, the line is fetched from physical line address {`xl_ppn`, `req_vaddr[11:5]`}, using the translation value sampled in the acceptance cycle. Memory line word k occupies `mem_rdata[32k+31:32k]`.
- R4: A store that hits updates the addressed word and marks the line dirty, with no memory transaction. A later load of that word returns the stored value.
- R5: The process identifier is part of the tag. The same virtual address accessed under a different identifier misses.
- R6: A miss whose victim is valid and dirty first writes the whole victim line (`mem_we` high) to its stored physical line address, then reads the new line. A clean victim is not written back.
- R7: A request accepted with `xl_fault` high completes with `resp_valid` and `resp_fault` both high. It changes no cache contents and causes no memory transaction.
- R8: A context switch with `ctx_flush` low loads `ctx_pid` and keeps all lines. Returning to an earlier identifier hits on that identifier's resident lines.
- R9: A context switch with `ctx_flush` high raises `busy` from the next cycle, writes back every valid dirty line, and invalidates every line before `busy` falls.
- R10: The set index is `req_vaddr[12:5]` and the virtual tag is `req_vaddr[31:13]`. Two addresses with the same index but different tags evict each other.
- R11: `req_vaddr[4:2]` selects the 32-bit word within the line, for both loads and stores.
- R12: Requests presented while `busy` is high are ignored: they produce no response and change no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request strobe |
| req_we | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| xl_ppn | input | 20 | Physical page number from translation, same cycle as the request |
| xl_fault | input | 1 | Translation or permission fault, same cycle as the request |
| ctx_valid | input | 1 | Context-switch command strobe |
| ctx_flush | input | 1 | Write back and invalidate all lines on this switch |
| ctx_pid | input | 8 | New process identifier |
| busy | output | 1 | Request or flush in progress |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_fault | output | 1 | Completion was a fault |
| resp_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory transaction pending, held until acknowledged |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_line_addr | output | 27 | Physical line address |
| mem_wdata | output | 256 | Write-back line |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | 256 | Refill line, valid with `mem_ack` |

## Verification
The assertions assume three things about the inputs. First, `mem_ack` arrives only while `mem_req` is pending and lasts one cycle. Second, the translation inputs are meaningful in the acceptance cycle. Third, any synonyms a caller creates agree in bit 12, so that every alias lands in the same set. The bench's memory model acknowledges each transaction exactly once, a few cycles after it sees the request. The bench changes the translation value only together with a request, and it never maps two virtual pages of different index to one physical page.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL,
    ST_FL_RD,
    ST_FL_CHK,
    ST_FL_WB
  } vtc_state_e;

endpackage

// File: rtl/vtc_sdp_ram.sv
module vtc_sdp_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/vtc_line_flags.sv
module vtc_line_flags #(
  parameter int NUM_LINES = 256,
  localparam int IDX_BITS = $clog2(NUM_LINES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_BITS-1:0] idx,
  input  logic                set_valid,
  input  logic                dirty_in,
  input  logic                mark_dirty,
  input  logic                clear,
  output logic                valid_o,
  output logic                dirty_o
);

  logic [NUM_LINES-1:0] vld_q;
  logic [NUM_LINES-1:0] drt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      drt_q <= '0;
    end else if (clear) begin
      vld_q[idx] <= 1'b0;
      drt_q[idx] <= 1'b0;
    end else if (set_valid) begin
      vld_q[idx] <= 1'b1;
      drt_q[idx] <= dirty_in;
    end else if (mark_dirty) begin
      drt_q[idx] <= 1'b1;
    end
  end

  assign valid_o = vld_q[idx];
  assign dirty_o = drt_q[idx];

endmodule

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
  import vtc_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BITS  = 12,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 256,
  parameter int PID_W      = 8,
  parameter int WORD_W     = 32,
  localparam int OFF_BITS  = $clog2(LINE_BYTES),
  localparam int IDX_BITS  = $clog2(NUM_LINES),
  localparam int VTAG_W    = VA_W - OFF_BITS - IDX_BITS,
  localparam int PPN_W     = PA_W - PAGE_BITS,
  localparam int LPA_W     = PA_W - OFF_BITS,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int TAG_W     = PID_W + VTAG_W + LPA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_we,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [WORD_W-1:0]   req_wdata,
  input  logic [PPN_W-1:0]    xl_ppn,
  input  logic                xl_fault,
  input  logic                ctx_valid,
  input  logic                ctx_flush,
  input  logic [PID_W-1:0]    ctx_pid,
  output logic                busy,
  output logic                resp_valid,
  output logic                resp_fault,
  output logic [WORD_W-1:0]   resp_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [LPA_W-1:0]    mem_line_addr,
  output logic [LINE_W-1:0]   mem_wdata,
  input  logic                mem_ack,
  input  logic [LINE_W-1:0]   mem_rdata,
  output logic [IDX_BITS-1:0] ram_raddr,
  output logic [IDX_BITS-1:0] line_idx,
  output logic                tag_we,
  output logic [TAG_W-1:0]    tag_wdata,
  input  logic [TAG_W-1:0]    tag_rdata,
  output logic                data_we,
  output logic [LINE_W-1:0]   data_wdata,
  input  logic [LINE_W-1:0]   data_rdata,
  output logic                fl_set,
  output logic                fl_dirty_in,
  output logic                fl_mark,
  output logic                fl_clr,
  input  logic                line_valid,
  input  logic                line_dirty
);

  localparam int WORDS  = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int POFF_W = PAGE_BITS - OFF_BITS;

  vtc_state_e          state_q;
  logic [IDX_BITS-1:0] idx_q;
  logic                we_q;
  logic                fault_q;
  logic [VTAG_W-1:0]   vtag_q;
  logic [WSEL_W-1:0]   woff_q;
  logic [POFF_W-1:0]   poff_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [PPN_W-1:0]    ppn_q;
  logic [PID_W-1:0]    pid_q;

  logic                resp_valid_q, resp_fault_q;
  logic [WORD_W-1:0]   resp_rdata_q;
  logic                mem_req_q, mem_we_q;
  logic [LPA_W-1:0]    mem_lpa_q;
  logic [LINE_W-1:0]   mem_wdata_q;

  logic [PID_W-1:0]    t_pid;
  logic [VTAG_W-1:0]   t_vtag;
  logic [LPA_W-1:0]    t_lpa;
  logic [LPA_W-1:0]    fill_lpa;
  logic                hit, victim, store_hit, fill_done, last_idx;
  logic [LINE_W-1:0]   fill_line, hit_line;
  logic                unused_low;

  assign unused_low = ^req_vaddr[BOFF_W-1:0];

  assign t_pid    = tag_rdata[TAG_W-1 -: PID_W];
  assign t_vtag   = tag_rdata[LPA_W +: VTAG_W];
  assign t_lpa    = tag_rdata[LPA_W-1:0];
  assign fill_lpa = {ppn_q, poff_q};

  assign hit       = line_valid && (t_vtag == vtag_q) && (t_pid == pid_q);
  assign victim    = line_valid && line_dirty;
  assign store_hit = (state_q == ST_LOOKUP) && !fault_q && hit && we_q;
  assign fill_done = (state_q == ST_FILL) && mem_ack;
  assign last_idx  = (idx_q == IDX_BITS'(NUM_LINES - 1));

  always_comb begin
    fill_line = mem_rdata;
    if (we_q) fill_line[woff_q*WORD_W +: WORD_W] = wdata_q;
    hit_line = data_rdata;
    hit_line[woff_q*WORD_W +: WORD_W] = wdata_q;
  end

  assign ram_raddr   = (state_q == ST_IDLE) ? req_vaddr[OFF_BITS +: IDX_BITS] : idx_q;
  assign line_idx    = idx_q;
  assign tag_we      = fill_done;
  assign tag_wdata   = {pid_q, vtag_q, fill_lpa};
  assign data_we     = store_hit || fill_done;
  assign data_wdata  = fill_done ? fill_line : hit_line;
  assign fl_set      = fill_done;
  assign fl_dirty_in = we_q;
  assign fl_mark     = store_hit;
  assign fl_clr      = ((state_q == ST_FL_CHK) && !victim) ||
                       ((state_q == ST_FL_WB) && mem_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      we_q         <= 1'b0;
      fault_q      <= 1'b0;
      vtag_q       <= '0;
      woff_q       <= '0;
      poff_q       <= '0;
      wdata_q      <= '0;
      ppn_q        <= '0;
      pid_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_fault_q <= 1'b0;
      resp_rdata_q <= '0;
      mem_req_q    <= 1'b0;
      mem_we_q     <= 1'b0;
      mem_lpa_q    <= '0;
      mem_wdata_q  <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      resp_fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ctx_valid) begin
            pid_q <= ctx_pid;
            if (ctx_flush) begin
              idx_q   <= '0;
              state_q <= ST_FL_RD;
            end
          end else if (req_valid) begin
            idx_q   <= req_vaddr[OFF_BITS +: IDX_BITS];
            vtag_q  <= req_vaddr[VA_W-1 -: VTAG_W];
            woff_q  <= req_vaddr[BOFF_W +: WSEL_W];
            poff_q  <= req_vaddr[OFF_BITS +: POFF_W];
            we_q    <= req_we;
            wdata_q <= req_wdata;
            ppn_q   <= xl_ppn;
            fault_q <= xl_fault;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (fault_q) begin
            resp_valid_q <= 1'b1;
            resp_fault_q <= 1'b1;
            state_q      <= ST_IDLE;
          end else if (hit) begin
            resp_valid_q <= 1'b1;
            resp_rdata_q <= we_q ? wdata_q : data_rdata[woff_q*WORD_W +: WORD_W];
            state_q      <= ST_IDLE;
          end else begin
            mem_req_q <= 1'b1;
            if (victim) begin
              mem_we_q    <= 1'b1;
              mem_lpa_q   <= t_lpa;
              mem_wdata_q <= data_rdata;
              state_q     <= ST_WB;
            end else begin
              mem_we_q  <= 1'b0;
              mem_lpa_q <= fill_lpa;
              state_q   <= ST_FILL;
            end
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            mem_we_q  <= 1'b0;
            mem_lpa_q <= fill_lpa;
            state_q   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_req_q    <= 1'b0;
            resp_valid_q <= 1'b1;
            resp_rdata_q <= fill_line[woff_q*WORD_W +: WORD_W];
            state_q      <= ST_IDLE;
          end
        end
        ST_FL_RD: state_q <= ST_FL_CHK;
        ST_FL_CHK: begin
          if (victim) begin
            mem_req_q   <= 1'b1;
            mem_we_q    <= 1'b1;
            mem_lpa_q   <= t_lpa;
            mem_wdata_q <= data_rdata;
            state_q     <= ST_FL_WB;
          end else if (last_idx) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_FL_RD;
          end
        end
        ST_FL_WB: begin
          if (mem_ack) begin
            mem_req_q <= 1'b0;
            mem_we_q  <= 1'b0;
            if (last_idx) begin
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_FL_RD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign resp_valid    = resp_valid_q;
  assign resp_fault    = resp_fault_q;
  assign resp_rdata    = resp_rdata_q;
  assign mem_req       = mem_req_q;
  assign mem_we        = mem_we_q;
  assign mem_line_addr = mem_lpa_q;
  assign mem_wdata     = mem_wdata_q;

endmodule

// File: rtl/vtc_cache.sv
module vtc_cache #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BITS  = 12,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 256,
  parameter int PID_W      = 8,
  parameter int WORD_W     = 32
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  input  logic                                 req_we,
  input  logic [VA_W-1:0]                      req_vaddr,
  input  logic [WORD_W-1:0]                    req_wdata,
  input  logic [PA_W-PAGE_BITS-1:0]            xl_ppn,
  input  logic                                 xl_fault,
  input  logic                                 ctx_valid,
  input  logic                                 ctx_flush,
  input  logic [PID_W-1:0]                     ctx_pid,
  output logic                                 busy,
  output logic                                 resp_valid,
  output logic                                 resp_fault,
  output logic [WORD_W-1:0]                    resp_rdata,
  output logic                                 mem_req,
  output logic                                 mem_we,
  output logic [PA_W-$clog2(LINE_BYTES)-1:0]   mem_line_addr,
  output logic [LINE_BYTES*8-1:0]              mem_wdata,
  input  logic                                 mem_ack,
  input  logic [LINE_BYTES*8-1:0]              mem_rdata
);

  localparam int OFF_BITS = $clog2(LINE_BYTES);
  localparam int IDX_BITS = $clog2(NUM_LINES);
  localparam int VTAG_W   = VA_W - OFF_BITS - IDX_BITS;
  localparam int LPA_W    = PA_W - OFF_BITS;
  localparam int LINE_W   = LINE_BYTES * 8;
  localparam int TAG_W    = PID_W + VTAG_W + LPA_W;

  logic [IDX_BITS-1:0] ram_raddr, line_idx;
  logic                tag_we, data_we;
  logic [TAG_W-1:0]    tag_wdata, tag_rdata;
  logic [LINE_W-1:0]   data_wdata, data_rdata;
  logic                fl_set, fl_dirty_in, fl_mark, fl_clr;
  logic                line_valid, line_dirty;

  vtc_sdp_ram #(.W(TAG_W), .DEPTH(NUM_LINES)) u_tag (
    .clk(clk), .we(tag_we), .waddr(line_idx), .wdata(tag_wdata),
    .raddr(ram_raddr), .rdata(tag_rdata)
  );

  vtc_sdp_ram #(.W(LINE_W), .DEPTH(NUM_LINES)) u_data (
    .clk(clk), .we(data_we), .waddr(line_idx), .wdata(data_wdata),
    .raddr(ram_raddr), .rdata(data_rdata)
  );

  vtc_line_flags #(.NUM_LINES(NUM_LINES)) u_flags (
    .clk(clk), .rst(rst), .idx(line_idx), .set_valid(fl_set),
    .dirty_in(fl_dirty_in), .mark_dirty(fl_mark), .clear(fl_clr),
    .valid_o(line_valid), .dirty_o(line_dirty)
  );

  vtc_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .LINE_BYTES(LINE_BYTES),
    .NUM_LINES(NUM_LINES), .PID_W(PID_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_we(req_we), .req_vaddr(req_vaddr),
    .req_wdata(req_wdata), .xl_ppn(xl_ppn), .xl_fault(xl_fault),
    .ctx_valid(ctx_valid), .ctx_flush(ctx_flush), .ctx_pid(ctx_pid),
    .busy(busy), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_line_addr(mem_line_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ram_raddr(ram_raddr), .line_idx(line_idx),
    .tag_we(tag_we), .tag_wdata(tag_wdata), .tag_rdata(tag_rdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .fl_set(fl_set), .fl_dirty_in(fl_dirty_in), .fl_mark(fl_mark),
    .fl_clr(fl_clr), .line_valid(line_valid), .line_dirty(line_dirty)
  );

endmodule

// File: rtl/vtc_checker.sv
module vtc_checker #(
  parameter int LPA_W  = 27,
  parameter int LINE_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              ctx_valid,
  input logic              ctx_flush,
  input logic              busy,
  input logic              resp_valid,
  input logic              resp_fault,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [LPA_W-1:0]  mem_line_addr,
  input logic [LINE_W-1:0] mem_wdata
);

  // R1: one cycle after reset is held, the block is quiet
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !resp_valid && !mem_req));

  // R2: an accepted request makes the block busy
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !ctx_valid) |=> busy);

  // R2: a response lasts exactly one cycle
  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R2: the block is free while it responds
  p_resp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !busy);

  // R7: a fault flag only comes with a response
  p_fault_with_resp_r7: assert property (@(posedge clk) disable iff (rst)
    resp_fault |-> resp_valid);

  // R6: a pending memory transaction holds its command until acknowledged
  p_mem_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                               $stable(mem_line_addr) && $stable(mem_wdata)));

  // R9: a flushing context switch makes the block busy
  p_flush_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (ctx_valid && ctx_flush && !busy) |=> busy);

  // R9: memory traffic only happens while busy
  p_mem_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

endmodule

bind vtc_cache vtc_checker #(
  .LPA_W(PA_W - $clog2(LINE_BYTES)),
  .LINE_W(LINE_BYTES * 8)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .ctx_valid(ctx_valid),
  .ctx_flush(ctx_flush), .busy(busy), .resp_valid(resp_valid),
  .resp_fault(resp_fault), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_line_addr(mem_line_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_vtc_cache.sv
`timescale 1ns/1ps
module tb_vtc_cache;

  localparam int LPA_W  = 27;
  localparam int LINE_W = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0, req_we = 1'b0;
  logic [31:0]       req_vaddr = '0, req_wdata = '0;
  logic [19:0]       xl_ppn = '0;
  logic              xl_fault = 1'b0;
  logic              ctx_valid = 1'b0, ctx_flush = 1'b0;
  logic [7:0]        ctx_pid = '0;
  logic              busy, resp_valid, resp_fault;
  logic [31:0]       resp_rdata;
  logic              mem_req, mem_we;
  logic [LPA_W-1:0]  mem_line_addr;
  logic [LINE_W-1:0] mem_wdata;
  logic              mem_ack = 1'b0;
  logic [LINE_W-1:0] mem_rdata = '0;

  int n_chk = 0, n_err = 0;
  int n_rd = 0, n_wr = 0, n_resp = 0;
  logic [LPA_W-1:0]  wb_lpa;
  logic [LINE_W-1:0] wb_line;
  logic [LINE_W-1:0] mem_store [logic [LPA_W-1:0]];

  always #2 clk = ~clk;

  vtc_cache dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata), .xl_ppn(xl_ppn),
    .xl_fault(xl_fault), .ctx_valid(ctx_valid), .ctx_flush(ctx_flush),
    .ctx_pid(ctx_pid), .busy(busy), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_rdata(resp_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_line_addr(mem_line_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] exp_word(logic [LPA_W-1:0] lpa, logic [2:0] w);
    return 32'h1000_0000 + {2'b00, lpa, 3'b000} + {29'd0, w};
  endfunction

  function automatic logic [LPA_W-1:0] lpa_of(logic [19:0] ppn, logic [31:0] va);
    return {ppn, va[11:5]};
  endfunction

  function automatic logic [LINE_W-1:0] line_of(logic [LPA_W-1:0] lpa);
    logic [LINE_W-1:0] l;
    if (mem_store.exists(lpa)) return mem_store[lpa];
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = exp_word(lpa, w[2:0]);
    return l;
  endfunction

  // memory model: acknowledge each pending transaction once
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (mem_we) begin
          n_wr++;
          wb_lpa  = mem_line_addr;
          wb_line = mem_wdata;
          mem_store[mem_line_addr] = mem_wdata;
          mem_rdata = '0;
        end else begin
          n_rd++;
          mem_rdata = line_of(mem_line_addr);
        end
        repeat (2) @(negedge clk);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (resp_valid) n_resp++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic access(input logic we, input logic [31:0] va, input logic [31:0] wd,
                        input logic [19:0] ppn, input logic flt,
                        output logic [31:0] rd, output logic rf, output int lat);
    wait_idle();
    req_valid = 1'b1; req_we = we; req_vaddr = va; req_wdata = wd;
    xl_ppn = ppn; xl_fault = flt;
    @(negedge clk);
    req_valid = 1'b0; xl_fault = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    rd = resp_rdata;
    rf = resp_fault;
  endtask

  task automatic ctx(input logic [7:0] pid, input logic fl);
    wait_idle();
    ctx_valid = 1'b1; ctx_flush = fl; ctx_pid = pid;
    @(negedge clk);
    ctx_valid = 1'b0; ctx_flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_fill_and_hit();
    logic [31:0] rd; logic rf; int lat; int r0, w0;
    ctx(8'h11, 1'b0);
    r0 = n_rd;
    access(1'b0, 32'h0000_1044, '0, 20'h00345, 1'b0, rd, rf, lat);
    chk("R1 first access misses", n_rd - r0, 1);
    chk("R3 refill address", {5'd0, wb_lpa_dummy(mem_line_addr)}, {5'd0, lpa_of(20'h00345, 32'h1044)});
    chk("R3 refill word", rd, exp_word(lpa_of(20'h00345, 32'h1044), 3'd1));
    r0 = n_rd; w0 = n_wr;
    access(1'b0, 32'h0000_104C, '0, 20'h00345, 1'b0, rd, rf, lat);
    chk("R2 hit no traffic", (n_rd - r0) + (n_wr - w0), 0);
    chk("R2 hit latency", lat, 2);
    chk("R11 word select", rd, exp_word(lpa_of(20'h00345, 32'h1044), 3'd3));
  endtask

  function automatic logic [LPA_W-1:0] wb_lpa_dummy(logic [LPA_W-1:0] a);
    return a;
  endfunction

  task automatic t_store_hit();
    logic [31:0] rd; logic rf; int lat; int r0, w0;
    r0 = n_rd; w0 = n_wr;
    access(1'b1, 32'h0000_104C, 32'hDEAD_BEEF, 20'h00345, 1'b0, rd, rf, lat);
    access(1'b0, 32'h0000_104C, '0, 20'h00345, 1'b0, rd, rf, lat);
    chk("R4 store hit no traffic", (n_rd - r0) + (n_wr - w0), 0);
    chk("R4 store readback", rd, 32'hDEAD_BEEF);
    access(1'b0, 32'h0000_1048, '0, 20'h00345, 1'b0, rd, rf, lat);
    chk("R11 neighbour word kept", rd, exp_word(lpa_of(20'h00345, 32'h1044), 3'd2));
    access(1'b0, 32'h0000_2000, '0, 20'h00500, 1'b0, rd, rf, lat);
    chk("R3 second line", rd, exp_word(lpa_of(20'h00500, 32'h2000), 3'd0));
  endtask

  task automatic t_homonym();
    logic [31:0] rd; logic rf; int lat; int r0, w0;
    ctx(8'h22, 1'b0);
    r0 = n_rd; w0 = n_wr;
    access(1'b0, 32'h0000_104C, '0, 20'h00777, 1'b0, rd, rf, lat);
    chk("R6 dirty victim written", n_wr - w0, 1);
    chk("R6 victim address", {5'd0, wb_lpa}, {5'd0, lpa_of(20'h00345, 32'h1044)});
    chk("R6 victim data", wb_line[3*32 +: 32], 32'hDEAD_BEEF);
    chk("R5 other process misses", n_rd - r0, 1);
    chk("R5 new process data", rd, exp_word(lpa_of(20'h00777, 32'h1044), 3'd3));
    ctx(8'h11, 1'b0);
    r0 = n_rd; w0 = n_wr;
    access(1'b0, 32'h0000_2000, '0, 20'h00500, 1'b0, rd, rf, lat);
    chk("R8 line kept across switch", (n_rd - r0) + (n_wr - w0), 0);
    chk("R8 kept data", rd, exp_word(lpa_of(20'h00500, 32'h2000), 3'd0));
  endtask

  task automatic t_conflict();
    logic [31:0] rd; logic rf; int lat; int r0, w0;
    r0 = n_rd; w0 = n_wr;
    access(1'b0, 32'h0000_4000, '0, 20'h00600, 1'b0, rd, rf, lat);
    chk("R10 conflicting tag misses", n_rd - r0, 1);
    chk("R6 clean victim not written", n_wr - w0, 0);
    r0 = n_rd;
    access(1'b0, 32'h0000_2000, '0, 20'h00500, 1'b0, rd, rf, lat);
    chk("R10 evicted line misses", n_rd - r0, 1);
  endtask

  task automatic t_fault();
    logic [31:0] rd; logic rf; int lat; int r0, w0;
    r0 = n_rd; w0 = n_wr;
    access(1'b1, 32'h0000_2000, 32'h1234_5678, 20'h00500, 1'b1, rd, rf, lat);
    chk("R7 fault flagged", {31'd0, rf}, 32'd1);
    access(1'b0, 32'h0000_2000, '0, 20'h00500, 1'b0, rd, rf, lat);
    chk("R7 no traffic", (n_rd - r0) + (n_wr - w0), 0);
    chk("R7 data untouched", rd, exp_word(lpa_of(20'h00500, 32'h2000), 3'd0));
    chk("R7 normal access not flagged", {31'd0, rf}, 32'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] rd; logic rf; int lat; int c0;
    wait_idle();
    c0 = n_resp;
    req_valid = 1'b1; req_we = 1'b0; req_vaddr = 32'h0000_2020; xl_ppn = 20'h00501;
    @(negedge clk);
    req_we = 1'b1; req_vaddr = 32'h0000_2000; req_wdata = 32'h0000_CAFE;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R12 single response", n_resp - c0, 1);
    access(1'b0, 32'h0000_2000, '0, 20'h00500, 1'b0, rd, rf, lat);
    chk("R12 ignored store had no effect", rd, exp_word(lpa_of(20'h00500, 32'h2000), 3'd0));
  endtask

  task automatic t_flush();
    logic [31:0] rd; logic rf; int lat; int r0, w0;
    access(1'b1, 32'h0000_2000, 32'h0000_1111, 20'h00500, 1'b0, rd, rf, lat);
    access(1'b1, 32'h0000_2020, 32'h0000_2222, 20'h00501, 1'b0, rd, rf, lat);
    w0 = n_wr;
    ctx(8'h33, 1'b1);
    chk("R9 busy during flush", {31'd0, busy}, 32'd1);
    wait_idle();
    chk("R9 dirty lines written", n_wr - w0, 2);
    ctx(8'h11, 1'b0);
    r0 = n_rd;
    access(1'b0, 32'h0000_2000, '0, 20'h00500, 1'b0, rd, rf, lat);
    chk("R9 lines invalidated", n_rd - r0, 1);
    chk("R9 written-back data refetched", rd, 32'h0000_1111);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got hung expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill_and_hit();
    t_store_hit();
    t_homonym();
    t_conflict();
    t_fault();
    t_busy_ignore();
    t_flush();
    summary();
  end

endmodule